// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces a system reset from two sources. The first is a power-good level from an external supply comparator. The second is a shared, bidirectional manual reset pin. Both inputs are asynchronous. Each one passes through a two-flop synchronizer and then a stability filter, so that short glitches are discarded. The block drives the active-low pin and a complementary active-high output, both in open-drain style. Each output has a drive enable and a level. When an output is not driven, the board pull resistor returns it to the inactive level.

A reset is held for as long as power-good is low. Once power-good returns, reset is held for a full timeout. A falling edge on the manual pin starts a timeout of the same minimum width, however short the external pulse is. Holding the pin low does not start another reset. The block's own drive of the pin is never taken for a new manual request. All lengths are parameters in clock cycles. The defaults assume a 200 MHz clock: 200 ms timeout, 100 ns pin filter and 40 ns power-good filter.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_ni` is low, reset is active: `rst_o`=1, `rst_n_o`=0, and both drive enables are 1.
- R2: After power-good goes high and stays high, reset is released exactly `TIMEOUT_CYC` cycles after the filtered power-good rises. Power-good is filtered by 2 sync stages plus `PG_DEB_CYC`.
- R3: A power-good drop lasting at least `PG_DEB_CYC` cycles makes reset active 3+`PG_DEB_CYC` cycles after the input change. Reset stays active for as long as power-good is low.
- R4: Only a high-to-low transition of the filtered pin starts a manual reset. Reset becomes active 3+`GLITCH_CYC` cycles after the pin falls. A pin held low starts no further reset.
- R5: Every manual reset stays active for exactly `TIMEOUT_CYC` cycles, even when the external pulse is shorter.
- R6: A pin low pulse shorter than `GLITCH_CYC` cycles starts no reset.
- R7: A power-good low pulse shorter than `PG_DEB_CYC` cycles starts no reset.
- R8: While the block is driving reset, falling edges on the pin are masked. Releasing the pin therefore never starts a second reset.
- R9: If power-good drops during a manual timeout, the counter is held at reload. A full `TIMEOUT_CYC` then runs from the filtered power-good return.
- R10: Outputs: `rst_n_oe_o` = `rst_oe_o` = `rst_o`. Also, `rst_n_o` = NOT `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Asynchronous power-good from comparator, 1 = supply above threshold |
| rst_pin_i | input | 1 | Sensed level of the shared active-low reset pin |
| rst_n_oe_o | output | 1 | Drive enable for the active-low pin (pulls it low) |
| rst_n_o | output | 1 | Level of the active-low reset |
| rst_oe_o | output | 1 | Drive enable for the active-high output (pulls it high) |
| rst_o | output | 1 | Level of the active-high reset |

## Verification
Each output edge is due a fixed number of cycles after its cause:
- A pin fall asserts reset after 3+`GLITCH_CYC` cycles.
- A power-good fall asserts reset after 3+`PG_DEB_CYC` cycles.
- A power-good rise releases reset after 2+`PG_DEB_CYC`+`TIMEOUT_CYC` cycles.
- A manual assertion is released `TIMEOUT_CYC` cycles after it began.

The driver computes each due cycle when it applies a stimulus and queues it. The monitor timestamps every output transition at the falling clock edge and compares it with the head of the queue. An early, late or unexpected edge is therefore reported, and so is an edge that never comes.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  // reset values of the filtered inputs: pin idles high, supply assumed bad
  localparam logic PIN_IDLE = 1'b1;
  localparam logic PG_IDLE  = 1'b0;
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/sup_level_filter.sv
module sup_level_filter #(
  parameter int   LEN     = 4,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int FW = $clog2(LEN + 1);
  localparam logic [FW-1:0] LAST = FW'(LEN - 1);

  logic [FW-1:0] cnt_q;
  logic          lvl_q;

  // new level accepted only after LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
  assign q_o = lvl_q;
endmodule

// File: rtl/sup_timeout_ctl.sv
module sup_timeout_ctl #(
  parameter int TIMEOUT_CYC = 50,
  parameter int CW          = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pg_ok_i,
  input  logic          start_i,
  output logic          active_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (!pg_ok_i || start_i) begin
      // supply low holds at reload; manual start reloads
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int TIMEOUT_CYC = 40_000_000, // 200 ms at 200 MHz
  parameter int GLITCH_CYC  = 20,         // 100 ns at 200 MHz
  parameter int PG_DEB_CYC  = 8           // 40 ns at 200 MHz
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic rst_pin_i,
  output logic rst_n_oe_o,
  output logic rst_n_o,
  output logic rst_oe_o,
  output logic rst_o
);
  import sup_rst_pkg::*;
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic          pg_sync, pin_sync;
  logic          pg_ok, pin_filt, pin_prev_q;
  logic          man_fall, active;
  logic [CW-1:0] cnt;

  sup_sync2 #(.RST_VAL(PG_IDLE)) pg_sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_good_i), .q_o(pg_sync));
  sup_sync2 #(.RST_VAL(PIN_IDLE)) pin_sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rst_pin_i), .q_o(pin_sync));

  sup_level_filter #(.LEN(PG_DEB_CYC), .RST_VAL(PG_IDLE)) pg_filt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pg_sync), .q_o(pg_ok));
  sup_level_filter #(.LEN(GLITCH_CYC), .RST_VAL(PIN_IDLE)) pin_filt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_sync), .q_o(pin_filt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_prev_q <= PIN_IDLE;
    else         pin_prev_q <= pin_filt;
  end

  // own drive of the pin must not look like a request
  assign man_fall = pin_prev_q & ~pin_filt & ~active;

  sup_timeout_ctl #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) tmo_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pg_ok_i(pg_ok), .start_i(man_fall),
    .active_o(active), .cnt_o(cnt));

  assign rst_n_oe_o = active;
  assign rst_n_o    = ~active;
  assign rst_oe_o   = active;
  assign rst_o      = active;
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk #(
  parameter int TIMEOUT_CYC = 50,
  parameter int CW          = $clog2(TIMEOUT_CYC + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pg_ok,
  input logic          man_fall,
  input logic [CW-1:0] cnt,
  input logic          rst_o,
  input logic          rst_n_o,
  input logic          rst_n_oe_o
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  // R3
  pg_low_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_ok |=> rst_o);
  // R9
  pg_low_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_ok |=> cnt == '0);
  // R5
  min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && cnt != LAST) |=> rst_o);
  // R2
  release_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> ($past(cnt) == LAST && $past(pg_ok)));
  // R8
  mask_own_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_fall |-> !rst_o);
  // R4
  start_asserts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_fall |=> (rst_o && cnt == '0));
  // R10
  polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_n_o == !rst_o) && (rst_n_oe_o == rst_o));
endmodule

bind sup_reset_gen sup_reset_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pg_ok(pg_ok), .man_fall(man_fall),
  .cnt(cnt), .rst_o(rst_o), .rst_n_o(rst_n_o), .rst_n_oe_o(rst_n_oe_o));

// File: tb/sup_reset_gen_tb_top.sv
`timescale 1ns/1ps
module sup_reset_gen_tb_top;
  localparam int T = 50;
  localparam int G = 4;
  localparam int P = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0;
  logic btn_n = 1'b1;
  logic pin;
  logic rst_n_oe, rst_n_lvl, rst_oe, rst_hi;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int pol_err = 0;
  logic prev_lvl = 1'b1;

  typedef struct {
    int    cyc;
    logic  lvl;
    string req;
  } exp_t;
  exp_t exp_q[$];

  // wired-AND of button and open-drain drive, pulled up
  assign pin = btn_n & ~rst_n_oe;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sup_reset_gen #(.TIMEOUT_CYC(T), .GLITCH_CYC(G), .PG_DEB_CYC(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .rst_pin_i(pin),
    .rst_n_oe_o(rst_n_oe), .rst_n_o(rst_n_lvl), .rst_oe_o(rst_oe), .rst_o(rst_hi));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_exp(input int c, input logic l, input string r);
    exp_t e;
    e.cyc = c; e.lvl = l; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every output transition must match the queue head
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_hi !== prev_lvl) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected edge", int'(rst_hi), int'(prev_lvl));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rst_hi === e.lvl && cyc == e.cyc, e.req, cyc, e.cyc);
        end
      end
      prev_lvl = rst_hi;
      if (rst_n_lvl !== ~rst_hi || rst_n_oe !== rst_hi || rst_oe !== rst_hi) pol_err++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int c;
    wait_cyc(3);
    // R1 reset state
    check(rst_hi === 1'b1 && rst_n_lvl === 1'b0, "R1 level", int'(rst_hi), 1);
    check(rst_n_oe === 1'b1 && rst_oe === 1'b1, "R1 enables", int'(rst_n_oe), 1);

    // R2 power-up timeout
    rst_n = 1'b1; pg = 1'b1; c = cyc;
    push_exp(c + 2 + P + T, 1'b0, "R2 power-up release");
    wait_cyc(T + 20);
    check(rst_hi === 1'b0 && rst_n_oe === 1'b0, "R2 released", int'(rst_hi), 0);

    // R4/R5 short manual pulse stretched; R8 no retrigger on release
    c = cyc; btn_n = 1'b0;
    push_exp(c + 3 + G, 1'b1, "R4 manual start");
    push_exp(c + 3 + G + T, 1'b0, "R5 minimum width");
    wait_cyc(10); btn_n = 1'b1;
    wait_cyc(T + 30);
    check(rst_hi === 1'b0, "R8 own drive not retriggering", int'(rst_hi), 0);

    // R6 pin glitch
    btn_n = 1'b0; wait_cyc(G - 1); btn_n = 1'b1;
    wait_cyc(30);
    check(rst_hi === 1'b0, "R6 pin glitch ignored", int'(rst_hi), 0);

    // R4 held low: single reset only
    c = cyc; btn_n = 1'b0;
    push_exp(c + 3 + G, 1'b1, "R4 held start");
    push_exp(c + 3 + G + T, 1'b0, "R5 held width");
    wait_cyc(3 * T);
    check(rst_hi === 1'b0, "R4 hold no retrigger", int'(rst_hi), 0);
    btn_n = 1'b1; wait_cyc(20);

    // R7 supply glitch
    pg = 1'b0; wait_cyc(P - 1); pg = 1'b1;
    wait_cyc(20);
    check(rst_hi === 1'b0, "R7 supply glitch ignored", int'(rst_hi), 0);

    // R3 supply drop, R2 full timeout on return
    c = cyc; pg = 1'b0;
    push_exp(c + 3 + P, 1'b1, "R3 brown-out assert");
    wait_cyc(20);
    check(rst_hi === 1'b1, "R3 held while low", int'(rst_hi), 1);
    pg = 1'b1;
    push_exp(c + 20 + 2 + P + T, 1'b0, "R2 release after return");
    wait_cyc(T + 30);

    // R9 supply drop during manual timeout
    c = cyc; btn_n = 1'b0;
    push_exp(c + 3 + G, 1'b1, "R9 manual start");
    wait_cyc(10); btn_n = 1'b1;
    wait_cyc(10); pg = 1'b0;
    wait_cyc(10); pg = 1'b1;
    push_exp(c + 30 + 2 + P + T, 1'b0, "R9 full timeout after return");
    wait_cyc(T + 40);

    check(exp_q.size() == 0, "R5 all edges seen", exp_q.size(), 0);
    check(pol_err == 0, "R10 polarity and enables", pol_err, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule